// File: doc/BRIEF.md
# Reloadable Countdown Timer with Watchdog Variant

This block is a single-register countdown timer for a processor's peripheral bus. Software writes a word to it. If the low 31 bits of that word (the count field) are nonzero, the timer loads them and counts down by one on every clock. When the count runs out, the block emits a one-cycle event. A write whose count field is zero stops the timer. A read returns the live count together with the reload flag.

Bit 31 of the written word turns on periodic operation. The count field is then kept as a reload value and loaded again each time the count runs out. This gives a steady interrupt every N cycles. The build parameter `WATCHDOG` selects one of two variants. In the interrupt variant the event drives `irq`. In the watchdog variant the event drives `reset_req` instead, `irq` never rises, and bit 31 is ignored. Software must keep rewriting the watchdog before it expires.

The control is a two-state machine. IDLE means the timer is stopped. RUN means it is counting down. The machine has five named transitions:

- START: IDLE to RUN on a write with a nonzero count field.
- RESTART: RUN to RUN on a write with a nonzero count field.
- STOP: any state to IDLE on a write with a zero count field.
- RELOAD: RUN to RUN when the count is 1, reload is on and no write is present.
- EXPIRE: RUN to IDLE when the count is 1, reload is off and no write is present.

Top module: `cdt_top`

## Requirements
- R1: A write with a nonzero count field (bits 30:0) loads that count at the clock edge that accepts the write, and the timer starts running. The next read shows the loaded count.
- R2: While running with no write present, the count falls by exactly one per clock.
- R3: A write with a nonzero count field while the timer is running replaces the count at once, and counting continues from the new value.
- R4: A write whose count field is zero stops the timer. It sets the count to 0, clears the reload flag and produces no event, whatever bit 31 holds.
- R5: In the interrupt variant, `irq` is high for exactly one cycle. That cycle is the first one in which the count has stepped from 1 to its next value.
- R6: A write with bit 31 set and count field N enables reload. The count is loaded again with N each time it would reach zero, so `irq` pulses every N cycles. The first pulse comes N cycles after the write.
- R7: Without reload, the timer stays at count 0 in IDLE after it expires and produces no further events until the next nonzero write.
- R8: A read returns the reload flag in bit 31 and the current count in bits 30:0.
- R9: In the watchdog variant, expiry pulses `reset_req` for one cycle and `irq` stays low. Bit 31 of a write is ignored: it reads back as 0 and the timer never reloads.
- R10: A write in the same cycle the count would expire takes precedence. The new value is loaded and no event is produced for that expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word: bit 31 reload request, bits 30:0 count |
| rd_data | output | 32 | Read word: bit 31 reload flag, bits 30:0 live count |
| irq | output | 1 | One-cycle expiry pulse (interrupt variant) |
| reset_req | output | 1 | One-cycle expiry pulse (watchdog variant) |

## Verification
The bench checks the exact cycle of expiry, so a design that fires on count 0 instead of the 1-to-0 step would be off by one and would be caught.

Periodic mode is checked across three back-to-back periods. This catches a reload that loses a cycle, or that drifts to N+1.

A restart mid-count and a write landing exactly on the expiry cycle expose designs that keep decrementing the old value or still emit the stale pulse.

A stop write carrying bit 31 must leave the timer idle and silent. A watchdog instance given bit 31 must neither reload nor raise `irq`.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cdt_state_t;

    typedef struct packed {
        logic load;
        logic clear;
        logic dec;
        logic reload;
        logic fire;
    } cdt_act_t;

endpackage

// File: rtl/cdt_fsm.sv
module cdt_fsm
    import cdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic     wr_nz,
    input  logic     cnt_is_one,
    input  logic     reload_on,
    output logic     running,
    output cdt_act_t act
);

    cdt_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        act     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && wr_nz) begin
                    act.load = 1'b1;      // START
                    state_d  = ST_RUN;
                end else if (wr_en) begin
                    act.clear = 1'b1;     // STOP
                end
            end
            ST_RUN: begin
                if (wr_en && wr_nz) begin
                    act.load = 1'b1;      // RESTART (also R10)
                end else if (wr_en) begin
                    act.clear = 1'b1;     // STOP
                    state_d   = ST_IDLE;
                end else if (cnt_is_one && reload_on) begin
                    act.reload = 1'b1;    // RELOAD
                    act.fire   = 1'b1;
                end else if (cnt_is_one) begin
                    act.dec  = 1'b1;      // EXPIRE
                    act.fire = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    act.dec = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign running = (state_q == ST_RUN);

    a_r7_idle_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !act.fire);

    a_r4_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_nz) |=> !running);

endmodule

// File: rtl/cdt_count.sv
module cdt_count
    import cdt_pkg::*;
#(
    parameter int CNT_W    = 31,
    parameter bit WATCHDOG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cdt_act_t         act,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             wr_flag,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             cnt_is_one
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    logic             flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rld_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (act.load) begin
                cnt_q  <= wr_cnt;
                rld_q  <= wr_cnt;
                flag_q <= wr_flag & ~WATCHDOG;
            end else if (act.clear) begin
                cnt_q  <= '0;
                flag_q <= 1'b0;
            end else if (act.reload) begin
                cnt_q <= rld_q;
            end else if (act.dec) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt        = cnt_q;
    assign flag       = flag_q;
    assign cnt_is_one = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

    a_r1_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        act.load |=> cnt_q == $past(wr_cnt));

    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (act.dec && !act.load && !act.clear) |=> cnt_q == $past(cnt_q) - 1'b1);

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |=> $stable(cnt_q));

endmodule

// File: rtl/cdt_top.sv
module cdt_top
    import cdt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit WATCHDOG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              reset_req
);

    localparam int CNT_W = DATA_W - 1;

    cdt_act_t         act;
    logic             running;
    logic             cnt_is_one;
    logic             flag;
    logic [CNT_W-1:0] cnt;
    logic             wr_nz;
    logic             fire_q;

    assign wr_nz = |wr_data[CNT_W-1:0];

    cdt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_nz      (wr_nz),
        .cnt_is_one (cnt_is_one),
        .reload_on  (flag),
        .running    (running),
        .act        (act)
    );

    cdt_count #(
        .CNT_W    (CNT_W),
        .WATCHDOG (WATCHDOG)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .wr_cnt     (wr_data[CNT_W-1:0]),
        .wr_flag    (wr_data[DATA_W-1]),
        .cnt        (cnt),
        .flag       (flag),
        .cnt_is_one (cnt_is_one)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= act.fire;
    end

    generate
        if (WATCHDOG) begin : g_wdog
            assign irq       = 1'b0;
            assign reset_req = fire_q;
            a_r9_wd_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_data[DATA_W-1]);
        end else begin : g_intr
            assign irq       = fire_q;
            assign reset_req = 1'b0;
        end
    endgenerate

    assign rd_data = {flag, cnt};

    a_r5_pulse_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || reset_req) |-> ($past(running) && $past(cnt_is_one) && !$past(wr_en)));

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !(irq || reset_req));

endmodule

// File: tb/cdt_top_tb_top.sv
module cdt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, reset_req;

    logic        w_wr_en = 1'b0;
    logic [31:0] w_wr_data = '0;
    logic [31:0] w_rd_data;
    logic        w_irq, w_reset_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cdt_top #(.DATA_W(32), .WATCHDOG(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .reset_req(reset_req)
    );

    cdt_top #(.DATA_W(32), .WATCHDOG(1'b1)) dut_wd_i (
        .clk(clk), .rst_n(rst_n), .wr_en(w_wr_en), .wr_data(w_wr_data),
        .rd_data(w_rd_data), .irq(w_irq), .reset_req(w_reset_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wr_wd(input logic [31:0] v);
        @(negedge clk);
        w_wr_en = 1'b1; w_wr_data = v;
        @(negedge clk);
        w_wr_en = 1'b0; w_wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R8 reset read", rd_data, 32'h0);
        check("R5 reset irq", {31'b0, irq}, 32'h0);
        check("R9 reset req", {31'b0, w_reset_req}, 32'h0);
    endtask

    task automatic t_oneshot;
        wr(32'd5);
        check("R1 loaded count", rd_data, 32'd5);
        idle(1);
        check("R2 decrement", rd_data, 32'd4);
        idle(3);
        check("R5 no early irq", {31'b0, irq}, 32'h0);
        check("R2 count one", rd_data, 32'd1);
        idle(1);
        check("R5 irq at expiry", {31'b0, irq}, 32'h1);
        check("R5 count zero", rd_data, 32'd0);
        idle(1);
        check("R5 irq one cycle", {31'b0, irq}, 32'h0);
        idle(8);
        check("R7 stays zero", rd_data, 32'd0);
        check("R7 no repeat irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_restart;
        wr(32'd10);
        idle(3);
        check("R2 midway", rd_data, 32'd7);
        wr(32'd20);
        check("R3 restart value", rd_data, 32'd20);
        idle(19);
        check("R3 no stale irq", {31'b0, irq}, 32'h0);
        check("R3 count one", rd_data, 32'd1);
        idle(1);
        check("R3 irq after restart", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_stop;
        int seen;
        seen = 0;
        wr(32'h8000_0006);
        idle(2);
        wr(32'h8000_0000);
        check("R4 stop read", rd_data, 32'h0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (irq) seen++;
        end
        check("R4 no event after stop", seen, 0);
        check("R4 remains stopped", rd_data, 32'h0);
    endtask

    task automatic t_reload;
        wr(32'h8000_0003);
        check("R8 flag and count", rd_data, 32'h8000_0003);
        for (int p = 1; p <= 3; p++) begin
            idle(2);
            check("R6 no irq mid period", {31'b0, irq}, 32'h0);
            idle(1);
            check("R6 periodic irq", {31'b0, irq}, 32'h1);
            check("R6 reloaded count", rd_data, 32'h8000_0003);
        end
        wr(32'd0);
        check("R4 clears flag", rd_data, 32'h0);
    endtask

    task automatic t_collide;
        wr(32'd4);
        idle(2);
        wr(32'd9);
        check("R10 new value loaded", rd_data, 32'd9);
        check("R10 no irq on collision", {31'b0, irq}, 32'h0);
        idle(1);
        check("R10 no late irq", {31'b0, irq}, 32'h0);
        wr(32'd0);
    endtask

    task automatic t_watchdog;
        wr_wd(32'h8000_0004);
        check("R9 flag ignored", w_rd_data, 32'd4);
        idle(3);
        check("R9 no early req", {31'b0, w_reset_req}, 32'h0);
        idle(1);
        check("R9 reset pulse", {31'b0, w_reset_req}, 32'h1);
        check("R9 irq never", {31'b0, w_irq}, 32'h0);
        check("R9 no reload", w_rd_data, 32'h0);
        idle(1);
        check("R9 pulse ends", {31'b0, w_reset_req}, 32'h0);
        idle(6);
        check("R9 stays idle", w_rd_data, 32'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_restart();
        t_stop();
        t_reload();
        t_collide();
        t_watchdog();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule